// File: doc/BRIEF.md
# Serial converter read controller

This block lives in the system clock domain and drives an external 10-bit successive-approximation converter over three wires. It produces a convert-start strobe and a divided serial clock, and it samples the converter's returned data line. The results come out as a 10-bit word with a one-cycle valid strobe. A host starts a single conversion with a pulse, or holds a level to keep conversions running back to back. Power-down sequences are separate commands.

The converter has no register interface. Its power state is set only by where the controller raises the convert-start strobe within a serial transfer. If the strobe goes high early in a short 8-clock transfer, the converter enters partial power-down. Doing this twice puts it into full power-down. A long low strobe wakes it again. The controller remembers which power state the converter is in. After leaving full power-down, it holds off further work until the reference has settled. After reset it runs one initialization conversion, discards its result, and waits the same settle time.

The serial clock half-period and the settle wait are parameters counted in system clock cycles. The defaults are a 2-cycle half-period (25 MHz from a 100 MHz clock, below the 28.8 MHz limit) and 200000 cycles (2 ms).

Top module: `adc_host_reader`

## Requirements
- R1: After reset, convert-start is high, the serial clock is low and busy is high. The block then runs one 16-clock initialization conversion and produces no valid pulse for it. Busy stays high for SETTLE_CYC cycles after that frame raises convert-start.
- R2: The serial clock holds each level for exactly HALF_DIV system cycles during a transfer. It is low, and convert-start is high, whenever busy is low.
- R3: A start pulse while idle and powered up lowers convert-start and produces 16 serial clock cycles. Convert-start stays low through the 16th falling edge, rises with it, and busy then drops.
- R4: On each rising serial clock edge k (k = 1..16, counted from the convert-start fall), the data line is sampled as frame bit k-1. The result holds frame bits 4..13, with bit 4 as the result MSB. Frame bits 0..3, 14 and 15 have no effect on the result.
- R5: While the continuous input is high in the idle, powered-up state, conversions are chained with no idle cycle between them. Each chained frame is 16 serial clocks. Convert-start rises after the 14th rising edge and before the 15th, and falls again right after the 16th falling edge. When the continuous input is low at the end of a frame, the chain stops after that frame.
- R6: A power-down request with the full flag at 0, while powered up, sends one 8-clock frame. Convert-start rises after the 4th rising edge and stays high. The converter is then in partial power-down, and no valid pulse is produced.
- R7: A power-down request with the full flag at 1, while powered up, sends two such 8-clock frames back to back. The same request in partial power-down sends one frame. Either way the result is full power-down.
- R8: A wake request while powered down sends a 16-clock frame with convert-start low throughout, rising after the 16th falling edge. Its result is discarded. From partial power-down, busy drops immediately after the frame.
- R9: A wake from full power-down keeps busy high for SETTLE_CYC cycles after convert-start rises.
- R10: These commands have no effect: start, continuous and power-down while busy; start and continuous while powered down; a partial power-down request while in partial power-down; and wake while powered up.
- R11: The valid strobe lasts one cycle per completed conversion. The result output holds its value until the next valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion |
| cont_i | input | 1 | Level: run conversions back to back |
| pd_req_i | input | 1 | Request power-down |
| pd_full_i | input | 1 | With pd_req_i: go to full rather than partial power-down |
| wake_i | input | 1 | Request wake from power-down |
| sdata_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| cnv_o | output | 1 | Convert-start strobe, active-low frame |
| result_o | output | 10 | Last conversion result |
| valid_o | output | 1 | One-cycle strobe: new result |
| busy_o | output | 1 | Transfer or settle wait in progress |

## Verification
The assertions assume the following about the inputs:
- HALF_DIV is at least 2.
- Commands are plain levels sampled on the system clock, so a command present in an idle cycle is taken at once.
- The data line is only sampled, never checked for timing, so it must change after the rising serial clock edge the controller just produced.

The stimulus meets these conditions as follows. A converter model updates the data line a delta after each rising serial clock. Every command is held for exactly one cycle, except the deliberately ignored start and continuous levels in power-down. A nonzero filler is driven into the six unused frame positions, so that a capture off by one position would show up in the result.

// File: rtl/adc_host_reader.sv
module adc_host_reader #(
  parameter int HALF_DIV   = 2,
  parameter int SETTLE_CYC = 200000,
  parameter int RES_W      = 10,
  parameter int FRAME_LEN  = 16,
  parameter int PD_LEN     = 8,
  parameter int CONT_RAISE = 14,
  parameter int PD_RAISE   = 4,
  parameter int LEAD_BITS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic             pd_req_i,
  input  logic             pd_full_i,
  input  logic             wake_i,
  input  logic             sdata_i,
  output logic             sclk_o,
  output logic             cnv_o,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o,
  output logic             busy_o
);
  localparam int DIV_W = $clog2(HALF_DIV);
  localparam int H_W   = $clog2(2 * FRAME_LEN + 1);
  localparam int ST_W  = $clog2(SETTLE_CYC + 1);
  localparam int AGE_W = $clog2(HALF_DIV + 1);
  localparam int RC_W  = $clog2(FRAME_LEN + 1) + 1;

  typedef enum logic [1:0] {S_INIT, S_IDLE, S_RUN, S_SETTLE} state_t;
  typedef enum logic [1:0] {K_CONV, K_PD, K_WAKE, K_INIT} kind_t;
  typedef enum logic [1:0] {M_ON, M_PPD, M_FPD} mode_t;

  state_t           state;
  kind_t            kind, nk;
  mode_t            mode;
  logic [DIV_W-1:0] div_cnt;
  logic [H_W-1:0]   hcnt;
  logic [ST_W-1:0]  settle_cnt;
  logic             chain_q, full_q, sclk_q, cnv_q, valid_q;
  logic [RES_W-1:0] sr, result_q;
  logic             launch, nchain, nfull;

  wire tick = (div_cnt == DIV_W'(HALF_DIV - 1));
  wire [H_W-1:0] cyc_num  = (hcnt >> 1) + H_W'(1);
  wire [H_W-1:0] len_c    = (kind == K_PD) ? H_W'(PD_LEN) : H_W'(FRAME_LEN);
  wire [H_W-1:0] raise_c  = (kind == K_PD) ? H_W'(PD_RAISE) :
                            (kind == K_CONV && chain_q) ? H_W'(CONT_RAISE) : len_c;
  wire capture = (cyc_num > H_W'(LEAD_BITS)) && (cyc_num <= H_W'(LEAD_BITS + RES_W));
  wire last    = (state == S_RUN) && tick && hcnt[0] && (cyc_num == len_c);

  wire go_pd   = (mode == M_ON) ? pd_req_i : (mode == M_PPD && pd_req_i && pd_full_i);
  wire go_wake = (mode != M_ON) && wake_i && !go_pd;
  wire go_cont = (mode == M_ON) && cont_i && !pd_req_i;
  wire go_one  = (mode == M_ON) && start_i && !pd_req_i;

  always_comb begin
    launch = 1'b0;
    nk     = K_CONV;
    nchain = 1'b0;
    nfull  = 1'b0;
    case (state)
      S_INIT: begin
        launch = 1'b1;
        nk     = K_INIT;
      end
      S_IDLE: begin
        if (go_pd) begin
          launch = 1'b1;
          nk     = K_PD;
          nfull  = pd_full_i && (mode == M_ON);
        end else if (go_wake) begin
          launch = 1'b1;
          nk     = K_WAKE;
        end else if (go_cont) begin
          launch = 1'b1;
          nchain = 1'b1;
        end else if (go_one) begin
          launch = 1'b1;
        end
      end
      S_RUN: begin
        if (last && kind == K_CONV && chain_q && cont_i) begin
          launch = 1'b1;
          nchain = 1'b1;
        end else if (last && kind == K_PD && full_q && mode == M_ON) begin
          launch = 1'b1;
          nk     = K_PD;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_INIT;
      kind       <= K_INIT;
      mode       <= M_ON;
      div_cnt    <= '0;
      hcnt       <= '0;
      settle_cnt <= '0;
      chain_q    <= 1'b0;
      full_q     <= 1'b0;
      sclk_q     <= 1'b0;
      cnv_q      <= 1'b1;
      valid_q    <= 1'b0;
      sr         <= '0;
      result_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      case (state)
        S_RUN: begin
          div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
          if (tick) begin
            hcnt   <= hcnt + H_W'(1);
            sclk_q <= !hcnt[0];
            if (!hcnt[0] && capture) sr <= {sr[RES_W-2:0], sdata_i};
            if (hcnt[0] && cyc_num == raise_c) cnv_q <= 1'b1;
          end
          if (last) begin
            state <= S_IDLE;
            case (kind)
              K_CONV: begin
                result_q <= sr;
                valid_q  <= 1'b1;
              end
              K_PD:   mode <= (mode == M_ON) ? M_PPD : M_FPD;
              K_WAKE: begin
                mode <= M_ON;
                if (mode == M_FPD) begin
                  state      <= S_SETTLE;
                  settle_cnt <= '0;
                end
              end
              default: begin
                state      <= S_SETTLE;
                settle_cnt <= '0;
              end
            endcase
          end
        end
        S_SETTLE: begin
          if (settle_cnt == ST_W'(SETTLE_CYC - 1)) state <= S_IDLE;
          else settle_cnt <= settle_cnt + ST_W'(1);
        end
        default: ;
      endcase
      if (launch) begin
        state   <= S_RUN;
        kind    <= nk;
        chain_q <= nchain;
        full_q  <= nfull;
        div_cnt <= '0;
        hcnt    <= '0;
        sclk_q  <= 1'b0;
        cnv_q   <= 1'b0;
      end
    end
  end

  assign sclk_o   = sclk_q;
  assign cnv_o    = cnv_q;
  assign result_o = result_q;
  assign valid_o  = valid_q;
  assign busy_o   = (state != S_IDLE);

  logic             sclk_d, cnv_d;
  logic [AGE_W-1:0] sclk_age;
  logic [RC_W-1:0]  rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      cnv_d    <= 1'b1;
      sclk_age <= AGE_W'(HALF_DIV);
      rise_cnt <= '0;
    end else begin
      sclk_d <= sclk_q;
      cnv_d  <= cnv_q;
      if (sclk_q != sclk_d) sclk_age <= AGE_W'(1);
      else if (sclk_age < AGE_W'(HALF_DIV)) sclk_age <= sclk_age + AGE_W'(1);
      if (cnv_d && !cnv_q) rise_cnt <= '0;
      else if (sclk_q && !sclk_d) rise_cnt <= rise_cnt + RC_W'(1);
    end
  end

  a_r2_sclk_half: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q != sclk_d) |-> (sclk_age >= AGE_W'(HALF_DIV)));
  a_r2_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!sclk_o && cnv_o));
  a_r3_fall_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_o) |-> !sclk_o);
  a_r5_raise_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> (rise_cnt == RC_W'(PD_RAISE) || rise_cnt == RC_W'(CONT_RAISE) ||
                      rise_cnt == RC_W'(FRAME_LEN)));
  a_r6_no_valid_down: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_ON) |-> !valid_o);
  a_r10_ignored_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && mode != M_ON && !wake_i && !(pd_req_i && pd_full_i && mode == M_PPD))
    |=> (!busy_o && cnv_o));
  a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
endmodule

// File: tb/adc_host_reader_tb.sv
module adc_host_reader_tb;
  localparam int HD = 2;
  localparam int ST = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cont = 1'b0, pd_req = 1'b0, pd_full = 1'b0, wake = 1'b0, sdata = 1'b0;
  logic sclk, cnv, valid, busy;
  logic [9:0] result;
  always #5 clk = ~clk;

  adc_host_reader #(.HALF_DIV(HD), .SETTLE_CYC(ST)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cont_i(cont), .pd_req_i(pd_req),
    .pd_full_i(pd_full), .wake_i(wake), .sdata_i(sdata), .sclk_o(sclk), .cnv_o(cnv),
    .result_o(result), .valid_o(valid), .busy_o(busy));

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // converter model
  int dev_edges = 0, fall_count = 0;
  logic [9:0] frame_code = '0, done_code = '0;
  function automatic logic [9:0] gen(input int n);
    return 10'((n * 37 + 11) % 1024);
  endfunction
  function automatic logic dbit(input logic [9:0] w, input int k);
    if (k >= 4 && k <= 13) return w[13-k];
    return 1'b1;
  endfunction
  initial forever begin
    @(negedge cnv); #1;
    frame_code = gen(fall_count);
    fall_count++;
    dev_edges = 0;
    sdata = dbit(frame_code, 0);
  end
  initial forever begin
    @(posedge sclk); #1;
    dev_edges++;
    sdata = dbit(frame_code, dev_edges);
  end
  initial forever begin
    @(posedge cnv); #1;
    done_code = frame_code;
  end

  // pin monitor
  int edges = 0, rise_at = 0, nvalid = 0, run_len = 0, min_run = 1000;
  logic sclk_prev = 1'b0, cnv_prev = 1'b1, valid_prev = 1'b0;
  logic [9:0] last_result = '0;
  bit cont_chk = 1'b0;
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (sclk !== sclk_prev) begin
        if (run_len < min_run) min_run = run_len;
        run_len = 1;
      end else run_len++;
      if (sclk && !sclk_prev) edges++;
      if (!cnv && cnv_prev) begin
        if (cont_chk) check("R5", "serial clocks per chained frame", edges, 16);
        edges = 0;
      end
      if (cnv && !cnv_prev) begin
        rise_at = edges;
        if (cont_chk) check("R5", "rising edges before strobe raise", rise_at, 14);
      end
      if (valid) begin
        nvalid++;
        last_result = result;
        check("R4", "result word", int'(result), int'(done_code));
        check("R11", "valid high on previous cycle", int'(valid_prev), 0);
      end
    end
    sclk_prev = sclk;
    cnv_prev = cnv;
    valid_prev = valid;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask
  task automatic wait_idle();
    while (busy) step();
  endtask
  task automatic settle_len(output int j);
    while (cnv !== 1'b0) step();
    while (cnv !== 1'b1) step();
    j = 0;
    while (busy) begin step(); j++; end
  endtask

  task automatic do_single(input string req);
    int v0, f0;
    v0 = nvalid; f0 = fall_count;
    start = 1'b1; step(); start = 1'b0;
    wait_idle();
    check(req, "frames for one start", fall_count - f0, 1);
    check(req, "valid pulses for one start", nvalid - v0, 1);
    check("R3", "rising edges before strobe raise", rise_at, 16);
    check("R3", "serial clocks in frame", edges, 16);
  endtask

  initial begin
    int j, f0, v0, gaps;
    repeat (3) step();
    check("R1", "strobe in reset", int'(cnv), 1);
    check("R1", "sclk in reset", int'(sclk), 0);
    check("R1", "busy in reset", int'(busy), 1);
    rst_n = 1'b1;
    step();
    check("R1", "busy after reset", int'(busy), 1);
    settle_len(j);
    check("R1", "settle after init frame", j, ST);
    check("R1", "init frames", fall_count, 1);
    check("R1", "init result discarded", nvalid, 0);
    check("R2", "idle sclk", int'(sclk), 0);
    check("R2", "idle strobe", int'(cnv), 1);

    for (int i = 0; i < 128; i++) do_single("R3");
    repeat (10) step();
    check("R11", "result held", int'(result), int'(last_result));
    check("R2", "shortest sclk level", min_run, HD);

    // continuous sweep over all codes
    v0 = nvalid; gaps = 0;
    cont_chk = 1'b1;
    cont = 1'b1;
    while (nvalid - v0 < 1024) begin
      step();
      if (!busy) gaps++;
    end
    cont = 1'b0;
    wait_idle();
    cont_chk = 1'b0;
    check("R5", "idle cycles inside chain", gaps, 0);
    check("R5", "valids after stop", nvalid - v0, 1025);

    // wake while powered up is ignored
    f0 = fall_count;
    wake = 1'b1; step(); wake = 1'b0;
    repeat (20) step();
    check("R10", "frames from wake while on", fall_count - f0, 0);

    // busy ignores start and power-down
    f0 = fall_count; v0 = nvalid;
    start = 1'b1; step(); start = 1'b0;
    repeat (10) step();
    pd_req = 1'b1; pd_full = 1'b1; start = 1'b1; step();
    pd_req = 1'b0; pd_full = 1'b0; start = 1'b0;
    wait_idle();
    check("R10", "frames with commands while busy", fall_count - f0, 1);
    check("R10", "valids with commands while busy", nvalid - v0, 1);
    do_single("R10");

    // partial power-down
    f0 = fall_count; v0 = nvalid;
    pd_req = 1'b1; step(); pd_req = 1'b0;
    wait_idle();
    check("R6", "partial frames", fall_count - f0, 1);
    check("R6", "rising edges before raise", rise_at, 4);
    check("R6", "serial clocks in frame", edges, 8);
    check("R6", "valids", nvalid - v0, 0);
    check("R6", "strobe after frame", int'(cnv), 1);

    // start, continuous and partial request ignored in partial power-down
    f0 = fall_count; gaps = 0;
    start = 1'b1; cont = 1'b1;
    for (int k = 0; k < 30; k++) begin step(); if (busy) gaps++; end
    start = 1'b0; cont = 1'b0;
    pd_req = 1'b1; step(); pd_req = 1'b0;
    repeat (20) step();
    check("R10", "frames while powered down", fall_count - f0, 0);
    check("R10", "busy cycles while powered down", gaps, 0);
    check("R10", "valids while powered down", nvalid - v0, 0);

    // wake from partial
    f0 = fall_count;
    wake = 1'b1; step(); wake = 1'b0;
    settle_len(j);
    check("R8", "wake frames", fall_count - f0, 1);
    check("R8", "rising edges before raise", rise_at, 16);
    check("R8", "busy after partial wake", j, 0);
    check("R8", "wake result discarded", nvalid - v0, 0);
    do_single("R8");

    // full power-down in one request
    f0 = fall_count; v0 = nvalid;
    pd_req = 1'b1; pd_full = 1'b1; step(); pd_req = 1'b0; pd_full = 1'b0;
    wait_idle();
    check("R7", "full frames", fall_count - f0, 2);
    check("R7", "rising edges before raise", rise_at, 4);
    check("R7", "valids", nvalid - v0, 0);
    f0 = fall_count;
    start = 1'b1; step(); start = 1'b0;
    repeat (20) step();
    check("R10", "start in full power-down", fall_count - f0, 0);
    wake = 1'b1; step(); wake = 1'b0;
    settle_len(j);
    check("R9", "settle after full wake", j, ST);
    check("R9", "wake result discarded", nvalid - v0, 0);
    do_single("R9");

    // partial then full from partial
    f0 = fall_count;
    pd_req = 1'b1; step(); pd_req = 1'b0;
    wait_idle();
    pd_req = 1'b1; pd_full = 1'b1; step(); pd_req = 1'b0; pd_full = 1'b0;
    wait_idle();
    check("R7", "frames partial then full", fall_count - f0, 2);
    wake = 1'b1; step(); wake = 1'b0;
    settle_len(j);
    check("R7", "settle after wake from full", j, ST);
    do_single("R3");
    check("R2", "shortest sclk level", min_run, HD);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule